// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block is a synchronous controller for one rank of extended-data-out DRAM. The rank has a single row strobe, eight byte-lane column strobes, a shared multiplexed address bus, a write strobe and an output-enable strobe. On the host side there is one request channel. A request carries a read or write flag, an 11-bit row, a 10-bit column, a 64-bit write word and eight byte enables. Completion comes back as a single-cycle done pulse, which carries the read word on a read.

The controller opens a row and then serves each further request to the same row as a page-mode column cycle: only the column strobes toggle. The row is closed when one of four things happens: the next request targets another row, no request is waiting, a refresh is pending, or the open row is close to the maximum allowed row-strobe low time. Every analog timing limit is given in nanoseconds and turned into whole clock cycles, rounded up, from a clock-period parameter.

An external refresh scheduler raises a request line. The controller takes it at the next burst boundary. It closes the row and grants the bus with all strobes idle, and accepts no host request until the scheduler reports completion.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row address (11 bits, on dram_addr[10:0]) is on the bus at least one clock before the row strobe falls and stays unchanged across that edge. The column (10 bits, on dram_addr[9:0], with bit 10 zero) is on the bus before the column strobes fall and stays unchanged across that edge.
- R2: For a read, the row strobe is low, all eight column strobes fall together, the write strobe is high and the output enable is low. The 64-bit word appears on rdata with a one-cycle done pulse. Done pulses come back in request order.
- R3: A write is an early write. The write strobe is low at least one clock before the column strobes fall, and the write word is driven (dq_oe high). Only the lanes whose enable bit req_be[i] is 1 strobe, where lane i is bits 8i+7:8i and column strobe i. Bytes in the other lanes keep their old value.
- R4: The row strobe stays low for at least 60 ns and high for at least 40 ns. Successive falls of the row strobe are at least 104 ns apart.
- R5: The column strobes fall at least 14 ns after the row strobe falls, and only while it is low. Each column strobe pulse lasts at least 10 ns. Between page cycles the column strobes stay high for at least 10 ns.
- R6: A same-row request that is waiting when a column access ends, with no refresh pending, runs in the open row without another row-strobe fall. Column-strobe falls within a row are at least 25 ns apart.
- R7: Read data is captured no earlier than 15 ns after the column strobes fall, no earlier than 60 ns after the row strobe falls, and, in page mode, no earlier than 35 ns after the previous column-strobe rise.
- R8: The row strobe is never held low for as long as the maximum low time. A long same-row burst is split into several row openings.
- R9: A refresh request takes priority over host requests. It is granted only with the row closed. While the grant is high, the row and column strobes are high and req_ready is low. After ref_done, the row precharge is respected before the next access.
- R10: After reset, all strobes are high (inactive), dq_oe, done and ref_gnt are low, and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken at this clock edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 11 | Row address |
| req_col | input | 10 | Column address |
| req_wdata | input | 64 | Write word |
| req_be | input | 8 | Byte-lane enables for writes |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Read word, valid with done |
| ref_req | input | 1 | Refresh wanted |
| ref_gnt | output | 1 | Bus handed to refresh |
| ref_done | input | 1 | Refresh finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 8 | Column strobes per lane, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed address |
| dq_out | output | 64 | Write data to the DRAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 64 | Read data from the DRAM |

## Verification
The bench builds the controller with a 20 ns clock period and shrinks the maximum row-low time to 400 ns. That makes a same-row burst of a few dozen requests cross the limit, so the forced row close and reopen happens inside a short run. At that period several limits round to a single clock while others take two or three. This exercises the ceiling conversion and the combined rules for the first access and for precharge. A behavioural DRAM model measures every strobe spacing in nanoseconds. It returns a poison word whenever data is sampled before its access time, so early sampling shows up as a data mismatch.

// File: rtl/edo_pkg.sv
// Package: shared state encoding and timing helpers for the EDO controller.
// Assumes timing values are positive integers in nanoseconds.
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROWSET,
        ST_ROWWAIT,
        ST_COL,
        ST_CASLO,
        ST_CLOSE,
        ST_PRE,
        ST_REF
    } edo_state_t;

    // Nanoseconds to whole clock cycles, rounded up.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_phase_cnt.sv
// Module: loadable down-counter that times each controller phase.
// Assumes: load has priority; the counter rests at zero; last flags zero.
module edo_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/edo_ras_window.sv
// Module: measures how long the row strobe has been low.
// Reports when the minimum low time is met and whether one more page
// cycle still fits below the maximum low time.
// Assumes: ras_n is the registered strobe output of the controller.
module edo_ras_window #(
    parameter int TRAS_CYC   = 6,
    parameter int RASP_CYC   = 12500,
    parameter int PAGE_LIMIT = 12490,
    localparam int CW        = $clog2(RASP_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    output logic tras_met,
    output logic page_ok
);
    logic [CW-1:0] cnt;

    // Cycles elapsed since the row strobe fell; cleared while high.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (ras_n)                  cnt <= '0;
        else if (cnt != CW'(RASP_CYC))   cnt <= cnt + 1'b1;
    end

    assign tras_met = (cnt >= CW'(TRAS_CYC - 1));
    assign page_ok  = (cnt <  CW'(PAGE_LIMIT));

    // R4: the strobe rises only after the minimum low time.
    a_r4_tras_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ($past(cnt) >= CW'(TRAS_CYC - 1)));

    // R8: the low time never reaches the maximum.
    a_r8_rasp_max: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (cnt < CW'(RASP_CYC)));
endmodule

// File: rtl/edo_page_ctrl.sv
// Module: EDO DRAM page-mode controller (top).
// One rank, one row strobe, per-lane column strobes, early writes only.
// Keeps a row open for same-row requests and closes it on a row change,
// an empty queue, a refresh request or the approach of the RAS-low limit.
// Assumes: timing parameters in ns; converted to cycles by rounding up.
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int ROW_W     = 11,
    parameter int COL_W     = 10,
    parameter int LANES     = 8,
    parameter int LANE_W    = 8,
    parameter int T_RAS_NS  = 60,
    parameter int T_RP_NS   = 40,
    parameter int T_RC_NS   = 104,
    parameter int T_RCD_NS  = 14,
    parameter int T_RAH_NS  = 10,
    parameter int T_CAS_NS  = 10,
    parameter int T_CP_NS   = 10,
    parameter int T_HPC_NS  = 25,
    parameter int T_CAC_NS  = 15,
    parameter int T_RAC_NS  = 60,
    parameter int T_CPA_NS  = 35,
    parameter int T_RASP_NS = 125000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ROW_W-1:0]           req_row,
    input  logic [COL_W-1:0]           req_col,
    input  logic [LANES*LANE_W-1:0]    req_wdata,
    input  logic [LANES-1:0]           req_be,
    output logic                       done,
    output logic [LANES*LANE_W-1:0]    rdata,
    input  logic                       ref_req,
    output logic                       ref_gnt,
    input  logic                       ref_done,
    output logic                       ras_n,
    output logic [LANES-1:0]           cas_n,
    output logic                       we_n,
    output logic                       oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [LANES*LANE_W-1:0]    dq_out,
    output logic                       dq_oe,
    input  logic [LANES*LANE_W-1:0]    dq_in
);
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    // Cycle counts derived from the ns limits.
    localparam int N_RAS  = ns2cyc(T_RAS_NS, CLK_NS);
    localparam int N_RP   = ns2cyc(T_RP_NS,  CLK_NS);
    localparam int N_RC   = ns2cyc(T_RC_NS,  CLK_NS);
    localparam int N_RCD  = ns2cyc(T_RCD_NS, CLK_NS);
    localparam int N_RAH  = ns2cyc(T_RAH_NS, CLK_NS);
    localparam int N_CAS  = ns2cyc(T_CAS_NS, CLK_NS);
    localparam int N_CP   = ns2cyc(T_CP_NS,  CLK_NS);
    localparam int N_HPC  = ns2cyc(T_HPC_NS, CLK_NS);
    localparam int N_CAC  = ns2cyc(T_CAC_NS, CLK_NS);
    localparam int N_RAC  = ns2cyc(T_RAC_NS, CLK_NS);
    localparam int N_CPA  = ns2cyc(T_CPA_NS, CLK_NS);
    localparam int N_RASP = T_RASP_NS / CLK_NS;

    // Phase lengths.
    localparam int N_CASL = imax(imax(N_CAS, N_CAC), 1);
    localparam int N_WAIT = imax(imax(N_RAH, 1), imax(N_RCD - 1, N_RAC - 1 - N_CASL));
    localparam int N_CPH  = imax(imax(N_CP, 1), imax(N_HPC - N_CASL, N_CPA - N_CASL));
    localparam int N_PRE  = imax(imax(N_RP, 1), N_RC - N_RAS);
    localparam int PAGE_LIMIT = N_RASP - (N_CPH + N_CASL + 3);
    localparam int PH_MAX = imax(imax(N_WAIT, N_CPH), imax(N_CASL, N_PRE));
    localparam int PH_W   = $clog2(PH_MAX + 1);

    edo_state_t          state, nxt;
    logic                ph_load, ph_last;
    logic [PH_W-1:0]     ph_val;
    logic                tras_met, page_ok;
    logic                same_row, take;
    logic [ROW_W-1:0]    lat_row;
    logic [COL_W-1:0]    lat_col;
    logic                lat_wr;
    logic [LANES-1:0]    lat_be;
    logic                cas_any;

    edo_phase_cnt #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    edo_ras_window #(
        .TRAS_CYC   (N_RAS),
        .RASP_CYC   (N_RASP),
        .PAGE_LIMIT (PAGE_LIMIT)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .tras_met (tras_met),
        .page_ok  (page_ok)
    );

    // Acceptance: idle with no refresh, or at the end of a same-row column access.
    assign same_row  = (req_row == lat_row);
    assign req_ready = ((state == ST_IDLE) && !ref_req) ||
                       ((state == ST_CASLO) && ph_last && same_row && !ref_req && page_ok);
    assign take      = req_valid && req_ready;
    assign ref_gnt   = (state == ST_REF);
    assign cas_any   = ~&cas_n;

    // Next-state and phase-length selection.
    always_comb begin
        nxt     = state;
        ph_load = 1'b0;
        ph_val  = '0;
        case (state)
            ST_IDLE: begin
                if (ref_req)        nxt = ST_REF;
                else if (req_valid) nxt = ST_ROWSET;
            end
            ST_ROWSET: begin
                nxt = ST_ROWWAIT; ph_load = 1'b1; ph_val = PH_W'(N_WAIT - 1);
            end
            ST_ROWWAIT: if (ph_last) begin
                nxt = ST_COL; ph_load = 1'b1; ph_val = '0;
            end
            ST_COL: if (ph_last) begin
                nxt = ST_CASLO; ph_load = 1'b1; ph_val = PH_W'(N_CASL - 1);
            end
            ST_CASLO: if (ph_last) begin
                if (take) begin
                    nxt = ST_COL; ph_load = 1'b1; ph_val = PH_W'(N_CPH - 1);
                end else begin
                    nxt = ST_CLOSE;
                end
            end
            ST_CLOSE: if (tras_met) begin
                nxt = ST_PRE; ph_load = 1'b1; ph_val = PH_W'(N_PRE - 1);
            end
            ST_PRE: if (ph_last) nxt = ST_IDLE;
            ST_REF: if (ref_done) begin
                nxt = ST_PRE; ph_load = 1'b1; ph_val = PH_W'(N_PRE - 1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Strobes, bus, request latch and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n     <= 1'b1;
            cas_n     <= '1;
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            dram_addr <= '0;
            dq_out    <= '0;
            dq_oe     <= 1'b0;
            rdata     <= '0;
            done      <= 1'b0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_wr    <= 1'b0;
            lat_be    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (take) begin
                    lat_row   <= req_row;
                    lat_col   <= req_col;
                    lat_wr    <= req_write;
                    lat_be    <= req_be;
                    dq_out    <= req_wdata;
                    dram_addr <= ADDR_W'(req_row);
                end
                ST_ROWSET: ras_n <= 1'b0;
                ST_ROWWAIT: if (ph_last) begin
                    dram_addr <= ADDR_W'(lat_col);
                    we_n      <= !lat_wr;
                    dq_oe     <= lat_wr;
                end
                ST_COL: if (ph_last) begin
                    cas_n <= lat_wr ? ~lat_be : '0;
                    oe_n  <= lat_wr;
                end
                ST_CASLO: if (ph_last) begin
                    cas_n <= '1;
                    oe_n  <= 1'b1;
                    done  <= 1'b1;
                    if (!lat_wr) rdata <= dq_in;
                    if (take) begin
                        lat_col   <= req_col;
                        lat_wr    <= req_write;
                        lat_be    <= req_be;
                        dq_out    <= req_wdata;
                        dram_addr <= ADDR_W'(req_col);
                        we_n      <= !req_write;
                        dq_oe     <= req_write;
                    end else begin
                        we_n  <= 1'b1;
                        dq_oe <= 1'b0;
                    end
                end
                ST_CLOSE: if (tras_met) ras_n <= 1'b1;
                default: ;
            endcase
        end
    end

    // R1: row address held across the row-strobe fall.
    a_r1_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(dram_addr));

    // R1/R5: column address held across the column fall, row open.
    a_r1_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_any) |-> ($stable(dram_addr) && !ras_n && $past(!ras_n)));

    // R3: early write, write strobe set up before the column strobes.
    a_r3_early_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_any) && !we_n) |-> ($past(!we_n) && dq_oe));

    // R2: a read strobes every lane and enables the output.
    a_r2_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_any) && we_n) |-> ((cas_n == '0) && !oe_n));

    // R9: during a refresh grant the strobes are idle and hosts are held off.
    a_r9_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (ras_n && (&cas_n) && !req_ready));
endmodule

// File: tb/tb_edo_page_ctrl.sv
`timescale 1ns/1ps
module tb_edo_page_ctrl;
    localparam int CLK_NS = 20;
    localparam int HALF   = CLK_NS / 2;
    localparam int RASP   = 400;
    localparam logic [63:0] POISON = 64'hDEAD_BEEF_0BAD_F00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [10:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        done;
    logic [63:0] rdata;
    logic        ref_req = 1'b0, ref_gnt, ref_done = 1'b0;
    logic        ras_n, we_n, oe_n, dq_oe;
    logic [7:0]  cas_n;
    logic [10:0] dram_addr;
    logic [63:0] dq_out;
    logic [63:0] dq_in = '0;

    int total = 0, bad = 0, cyc = 0, ras_falls = 0, gnt_cycles = 0;

    edo_page_ctrl #(.CLK_NS(CLK_NS), .T_RASP_NS(RASP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_be(req_be), .done(done), .rdata(rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .ref_done(ref_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    always #HALF clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] init_word(input int r, input int c);
        return {r[15:0] ^ 16'hA5C3, c[15:0], ~r[15:0], c[15:0] ^ 16'h3C5A};
    endfunction

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw, input logic [7:0] be);
        logic [63:0] m = old;
        for (int i = 0; i < 8; i++) if (be[i]) m[8*i +: 8] = nw[8*i +: 8];
        return m;
    endfunction

    // DRAM contents (model) and expected contents (reference).
    logic [63:0] dram_mem [int];
    logic [63:0] ref_mem  [int];
    logic [64:0] exp_q [$];

    function automatic logic [63:0] dram_rd(input int key);
        return dram_mem.exists(key) ? dram_mem[key] : init_word(key / 1024, key % 1024);
    endfunction
    function automatic logic [63:0] ref_rd(input int key);
        return ref_mem.exists(key) ? ref_mem[key] : init_word(key / 1024, key % 1024);
    endfunction

    // Behavioural DRAM: timing checks in ns and time-gated read data.
    longint ras_fall_t = -1, ras_rise_t = -1, cas_fall_t = -1, cas_rise_t = -1, rise_before = -1;
    logic   p_ras = 1'b1, p_cas = 1'b0;
    int     m_row = 0, m_col = 0;

    always @(negedge clk) begin
        longint te, tn;
        logic   ca;
        te = $time - HALF;
        tn = $time + HALF;
        ca = ~&cas_n;
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                ras_falls++;
                if (ras_rise_t >= 0) chk(te - ras_rise_t >= 40, "R4 precharge", te - ras_rise_t, 40);
                if (ras_fall_t >= 0) chk(te - ras_fall_t >= 104, "R4 cycle", te - ras_fall_t, 104);
                ras_fall_t = te;
                m_row = int'(dram_addr);
                cas_rise_t = -1;
                cas_fall_t = -1;
            end
            if (!p_ras && ras_n) begin
                chk(te - ras_fall_t >= 60, "R4 low time", te - ras_fall_t, 60);
                chk(te - ras_fall_t < RASP, "R8 max low", te - ras_fall_t, RASP);
                ras_rise_t = te;
            end
            if (!p_cas && ca) begin
                chk(!ras_n, "R5 row open", ras_n, 0);
                chk(te - ras_fall_t >= 14, "R5 ras-to-cas", te - ras_fall_t, 14);
                if (cas_rise_t >= 0) chk(te - cas_rise_t >= 10, "R5 cas precharge", te - cas_rise_t, 10);
                if (cas_fall_t >= 0) chk(te - cas_fall_t >= 25, "R6 page cycle", te - cas_fall_t, 25);
                m_col = int'(dram_addr[9:0]);
                chk(dram_addr[10] == 1'b0, "R1 column bit10", dram_addr, 0);
                rise_before = cas_rise_t;
                cas_fall_t = te;
                if (!we_n) begin
                    chk(dq_oe, "R3 data driven", dq_oe, 1);
                    dram_mem[m_row * 1024 + m_col] = merge(dram_rd(m_row * 1024 + m_col), dq_out, ~cas_n);
                end else begin
                    chk(cas_n == 8'h00 && !oe_n, "R2 read strobes", {cas_n, 7'd0, oe_n}, 0);
                end
            end
            if (p_cas && !ca) begin
                chk(te - cas_fall_t >= 10, "R5 cas width", te - cas_fall_t, 10);
                cas_rise_t = te;
            end
            if (ca && we_n && (tn - cas_fall_t >= 15) && (tn - ras_fall_t >= 60) &&
                (rise_before < 0 || tn - rise_before >= 35))
                dq_in = dram_rd(m_row * 1024 + m_col);
            else
                dq_in = POISON;
            // Completion compare against the in-order expectation queue.
            if (done) begin
                if (exp_q.size() == 0) chk(0, "R2 extra done", 1, 0);
                else begin
                    logic [64:0] e;
                    e = exp_q.pop_front();
                    if (e[64]) chk(rdata == e[63:0], "R2 R7 read data", rdata, e[63:0]);
                    else       chk(1, "R3 write done", 0, 0);
                end
            end
            // R9: per-cycle check while refresh owns the bus.
            if (ref_gnt) begin
                gnt_cycles++;
                chk(ras_n && (&cas_n), "R9 strobes idle", {ras_n, cas_n}, 9'h1FF);
                chk(!req_ready, "R9 host held off", req_ready, 0);
            end
        end
        p_ras = ras_n;
        p_cas = ca;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic issue(input bit wr, input int r, input int c, input logic [63:0] d, input logic [7:0] be);
        int key;
        req_valid = 1'b1; req_write = wr; req_row = 11'(r); req_col = 10'(c);
        req_wdata = d; req_be = be;
        do @(negedge clk); while (!req_ready);
        key = r * 1024 + c;
        if (wr) begin
            ref_mem[key] = merge(ref_rd(key), d, be);
            exp_q.push_back({1'b0, 64'd0});
        end else begin
            exp_q.push_back({1'b1, ref_rd(key)});
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        int f0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state.
        chk(ras_n && cas_n == 8'hFF && we_n && oe_n, "R10 strobes", {ras_n, cas_n, we_n, oe_n}, 11'h7FF);
        chk(!dq_oe && !done && !ref_gnt, "R10 outputs", {dq_oe, done, ref_gnt}, 0);
        @(posedge clk); #1;

        // R3 R2: full write then read back.
        issue(1, 5, 3, 64'h0123_4567_89AB_CDEF, 8'hFF); drain();
        issue(0, 5, 3, 0, 0); drain();
        // R3: partial byte write keeps unselected lanes.
        issue(1, 5, 3, 64'hFFEE_DDCC_BBAA_9988, 8'h5A); drain();
        issue(0, 5, 3, 0, 0); drain();

        // R6: same-row read burst opens the row once.
        f0 = ras_falls;
        for (int i = 0; i < 4; i++) issue(0, 7, i, 0, 0);
        drain();
        chk(ras_falls - f0 == 1, "R6 one row open", ras_falls - f0, 1);

        // R6 R3: mixed write/read burst in one row.
        f0 = ras_falls;
        issue(1, 8, 10, 64'hA1A2_A3A4_A5A6_A7A8, 8'h0F);
        issue(1, 8, 11, 64'hB1B2_B3B4_B5B6_B7B8, 8'hF0);
        issue(0, 8, 10, 0, 0);
        issue(0, 8, 11, 0, 0);
        drain();
        chk(ras_falls - f0 == 1, "R6 mixed burst", ras_falls - f0, 1);

        // R4 R6: row change forces a close.
        f0 = ras_falls;
        issue(0, 3, 1, 0, 0); issue(0, 4, 1, 0, 0); issue(0, 3, 2, 0, 0);
        drain();
        chk(ras_falls - f0 == 3, "R4 row changes", ras_falls - f0, 3);

        // R1: extreme row and column.
        issue(1, 2047, 1023, 64'h5555_AAAA_3333_CCCC, 8'hFF);
        issue(0, 2047, 1023, 0, 0);
        issue(0, 0, 0, 0, 0);
        drain();

        // R8: long burst must be split before the maximum low time.
        f0 = ras_falls;
        for (int i = 0; i < 24; i++) issue(0, 12, i, 0, 0);
        drain();
        chk(ras_falls - f0 >= 2, "R8 burst split", ras_falls - f0, 2);

        // R9: refresh arrives during a burst.
        f0 = ras_falls;
        fork
            begin
                for (int i = 0; i < 8; i++) issue(0, 9, i, 0, 0);
            end
            begin
                repeat (4) @(posedge clk); #1 ref_req = 1'b1;
                do @(negedge clk); while (!ref_gnt);
                @(posedge clk); #1 ref_req = 1'b0;
                repeat (3) @(posedge clk); #1 ref_done = 1'b1;
                @(posedge clk); #1 ref_done = 1'b0;
            end
        join
        drain();
        chk(gnt_cycles > 0, "R9 grant seen", gnt_cycles, 1);
        chk(ras_falls - f0 >= 2, "R9 burst reopened", ras_falls - f0, 2);

        // R9: refresh and host request together at idle, refresh first.
        gnt_cycles = 0;
        f0 = ras_falls;
        ref_req = 1'b1;
        fork
            issue(0, 6, 6, 0, 0);
            begin
                do @(negedge clk); while (!ref_gnt);
                chk(ras_falls == f0, "R9 priority", ras_falls - f0, 0);
                @(posedge clk); #1 ref_req = 1'b0;
                repeat (2) @(posedge clk); #1 ref_done = 1'b1;
                @(posedge clk); #1 ref_done = 1'b0;
            end
        join
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule